// File: doc/BRIEF.md
# Program/Erase Suspend Arbiter

This block watches over the internal modify cycle of a serial flash device: a page program, a subsector or sector erase, a bulk erase, a one-time-programmable area program, a status register write or a nonvolatile configuration write. A command front end hands it one decoded command per clock, as a valid strobe and a 4-bit kind code. For each command the arbiter decides whether it may act. It starts, pauses and restarts the external modify-cycle timer. It reports whether the device is busy or suspended.

While a cycle runs, memory array reads and new modify commands are turned away, and the cycle goes on untouched. The two polling commands are always accepted, and each returns one bit: status poll gives the write-in-progress bit, flag poll gives the controller-ready bit. A suspend command pauses only program and subsector/sector erase cycles. A resume command restarts the paused cycle. While a cycle is suspended, the array may be read, but no further modify cycle may begin. The timer reports the end of a cycle with a one-clock done pulse.

Every decision, poll answer and timer control appears registered, one clock after the command is presented. The busy and suspended flags change on the same edge.

Top module: `pe_suspend_arbiter`

## Requirements
- R1: After reset, busy_o=0, suspended_o=0, ready_o=1, and accept_o, ignore_o, resp_bit_o and all three timer pulses are 0.
- R2: From idle, the codes 1 (program), 2 (subsector erase), 3 (sector erase), 4 (bulk erase), 5 (OTP program), 6 (status write) and 7 (nonvolatile configuration write) are accepted. They raise busy_o and give a one-clock tmr_start_o, all one clock after the command. Code 0 (array read) from idle is accepted and starts nothing.
- R3: While running (busy_o=1), an array read (code 0) or any modify code 1..7 is ignored, and busy_o stays 1.
- R4: Code 10 (status poll) and code 11 (flag poll) are accepted in every state. The answer appears on resp_bit_o with accept_o. Status poll returns 1 only while running. Flag poll returns 0 only while running.
- R5: Code 8 (suspend) while a cycle of kind 1, 2 or 3 runs is accepted. One clock later, suspended_o=1, busy_o=0, ready_o=1, and a one-clock tmr_pause_o is given.
- R6: Suspend while a cycle of kind 4, 5, 6 or 7 runs is ignored. No pause pulse is given, and busy_o stays 1.
- R7: Code 9 (resume) while suspended is accepted. One clock later, busy_o=1, suspended_o=0, and a one-clock tmr_resume_o is given.
- R8: Resume while idle or running, and suspend while idle or suspended, are ignored and give no timer pulse.
- R9: While suspended, an array read is accepted, a modify code 1..7 is ignored, and tmr_done_i is ignored. The device stays suspended.
- R10: tmr_done_i while running returns the block to idle on the next edge. A command presented in the same clock is judged against the running state, except that a suspend in that clock is ignored.
- R11: Every valid command yields exactly one of accept_o or ignore_o one clock later. The codes 12..15 are always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | A decoded command is present this clock |
| cmd_code_i | input | 4 | Command kind code (see requirements) |
| tmr_done_i | input | 1 | One-clock pulse: modify cycle finished |
| busy_o | output | 1 | Cycle running and not suspended |
| suspended_o | output | 1 | Cycle paused by suspend |
| ready_o | output | 1 | Controller-ready bit (inverse of busy_o) |
| accept_o | output | 1 | Previous command accepted |
| ignore_o | output | 1 | Previous command ignored |
| resp_bit_o | output | 1 | Answer to a poll accepted in the previous clock |
| tmr_start_o | output | 1 | Start the modify-cycle timer |
| tmr_pause_o | output | 1 | Freeze the timer |
| tmr_resume_o | output | 1 | Let the timer continue |

## Verification
Each command class is presented in each of the three states: idle, running and suspended. This separates a decision that truly depends on the state from one that is fixed per code. Suspend is tried against every one of the seven cycle kinds, which tells the pausable kinds from those that must keep running. The done pulse is given alone, together with a suspend in the same clock, and while suspended; these three cases tell apart which input wins and whether a paused cycle can end early. Unknown codes and resume/suspend in the wrong state check that misplaced commands leave the state unchanged.

// File: rtl/pe_arb_pkg.sv
package pe_arb_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_ARRAY_READ   = 4'd0,
        CMD_PROGRAM      = 4'd1,
        CMD_SUB_ERASE    = 4'd2,
        CMD_SEC_ERASE    = 4'd3,
        CMD_BULK_ERASE   = 4'd4,
        CMD_OTP_PROGRAM  = 4'd5,
        CMD_STATUS_WRITE = 4'd6,
        CMD_NVCFG_WRITE  = 4'd7,
        CMD_SUSPEND      = 4'd8,
        CMD_RESUME       = 4'd9,
        CMD_POLL_STATUS  = 4'd10,
        CMD_POLL_FLAG    = 4'd11
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic is_read;
        logic is_start;
        logic start_susp;
        logic is_suspend;
        logic is_resume;
        logic is_poll_status;
        logic is_poll_flag;
    } cmd_class_t;

    typedef struct packed {
        logic accept;
        logic ignore;
        logic resp_bit;
        logic tmr_start;
        logic tmr_pause;
        logic tmr_resume;
    } decision_t;

    function automatic cmd_class_t classify(input logic [CMD_W-1:0] code);
        cmd_class_t c;
        c = '0;
        case (cmd_kind_e'(code))
            CMD_ARRAY_READ: c.is_read = 1'b1;
            CMD_PROGRAM, CMD_SUB_ERASE, CMD_SEC_ERASE: begin
                c.is_start   = 1'b1;
                c.start_susp = 1'b1;
            end
            CMD_BULK_ERASE, CMD_OTP_PROGRAM,
            CMD_STATUS_WRITE, CMD_NVCFG_WRITE: c.is_start = 1'b1;
            CMD_SUSPEND:     c.is_suspend     = 1'b1;
            CMD_RESUME:      c.is_resume      = 1'b1;
            CMD_POLL_STATUS: c.is_poll_status = 1'b1;
            CMD_POLL_FLAG:   c.is_poll_flag   = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pe_arb_decode.sv
module pe_arb_decode
    import pe_arb_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] code_i,
    output cmd_class_t       cls_o
);

    assign cls_o = valid_i ? classify(code_i) : '0;

endmodule

// File: rtl/pe_arb_cycle_fsm.sv
module pe_arb_cycle_fsm
    import pe_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid_i,
    input  cmd_class_t cls_i,
    input  logic       done_i,
    output cyc_state_e state_o,
    output decision_t  dec_o
);

    cyc_state_e state_q, state_d;
    logic       susp_ok_q, susp_ok_d;
    logic       is_poll;

    assign is_poll = cls_i.is_poll_status | cls_i.is_poll_flag;

    always_comb begin
        state_d   = state_q;
        susp_ok_d = susp_ok_q;
        dec_o     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cls_i.is_start) begin
                    state_d         = ST_RUN;
                    susp_ok_d       = cls_i.start_susp;
                    dec_o.accept    = 1'b1;
                    dec_o.tmr_start = 1'b1;
                end else if (cls_i.is_read || is_poll) begin
                    dec_o.accept   = 1'b1;
                    dec_o.resp_bit = cls_i.is_poll_flag;
                end else if (valid_i) begin
                    dec_o.ignore = 1'b1;
                end
            end
            ST_RUN: begin
                if (done_i) state_d = ST_IDLE;
                if (is_poll) begin
                    dec_o.accept   = 1'b1;
                    dec_o.resp_bit = cls_i.is_poll_status;
                end else if (cls_i.is_suspend && susp_ok_q && !done_i) begin
                    state_d         = ST_SUSP;
                    dec_o.accept    = 1'b1;
                    dec_o.tmr_pause = 1'b1;
                end else if (valid_i) begin
                    dec_o.ignore = 1'b1;
                end
            end
            ST_SUSP: begin
                if (cls_i.is_resume) begin
                    state_d          = ST_RUN;
                    dec_o.accept     = 1'b1;
                    dec_o.tmr_resume = 1'b1;
                end else if (cls_i.is_read || is_poll) begin
                    dec_o.accept   = 1'b1;
                    dec_o.resp_bit = cls_i.is_poll_flag;
                end else if (valid_i) begin
                    dec_o.ignore = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            susp_ok_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            susp_ok_q <= susp_ok_d;
        end
    end

    assign state_o = state_q;

    // R6: a non-pausable running cycle never enters suspend
    p_hold_nonsusp_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !susp_ok_q) |=> (state_q != ST_SUSP));

    // R9: only resume leaves the suspended state
    p_susp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SUSP && !cls_i.is_resume) |=> (state_q == ST_SUSP));

    // R10: done while running always ends the cycle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && done_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pe_arb_resp_reg.sv
module pe_arb_resp_reg
    import pe_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec_i,
    output decision_t dec_o
);

    decision_t dec_q;

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_i;
    end

    assign dec_o = dec_q;

endmodule

// File: rtl/pe_suspend_arbiter.sv
module pe_suspend_arbiter
    import pe_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    input  logic             tmr_done_i,
    output logic             busy_o,
    output logic             suspended_o,
    output logic             ready_o,
    output logic             accept_o,
    output logic             ignore_o,
    output logic             resp_bit_o,
    output logic             tmr_start_o,
    output logic             tmr_pause_o,
    output logic             tmr_resume_o
);

    cmd_class_t cls;
    cyc_state_e state;
    decision_t  dec_now, dec_reg;

    pe_arb_decode u_decode (
        .valid_i (cmd_valid_i),
        .code_i  (cmd_code_i),
        .cls_o   (cls)
    );

    pe_arb_cycle_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .valid_i (cmd_valid_i),
        .cls_i   (cls),
        .done_i  (tmr_done_i),
        .state_o (state),
        .dec_o   (dec_now)
    );

    pe_arb_resp_reg u_resp (
        .clk   (clk),
        .rst   (rst),
        .dec_i (dec_now),
        .dec_o (dec_reg)
    );

    assign busy_o       = (state == ST_RUN);
    assign suspended_o  = (state == ST_SUSP);
    assign ready_o      = ~busy_o;
    assign accept_o     = dec_reg.accept;
    assign ignore_o     = dec_reg.ignore;
    assign resp_bit_o   = dec_reg.resp_bit;
    assign tmr_start_o  = dec_reg.tmr_start;
    assign tmr_pause_o  = dec_reg.tmr_pause;
    assign tmr_resume_o = dec_reg.tmr_resume;

    // R11: one verdict per valid command
    p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i |=> (accept_o ^ ignore_o));

    // R5: entering suspend comes with a pause pulse
    p_pause_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(suspended_o) |-> tmr_pause_o);

    // R7: resume pulse coincides with running again
    p_resume_run_r7: assert property (@(posedge clk) disable iff (rst)
        tmr_resume_o |-> busy_o);

    // R2: start pulse coincides with busy
    p_start_run_r2: assert property (@(posedge clk) disable iff (rst)
        tmr_start_o |-> busy_o);

    // R8: suspend/resume from idle is ignored
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !suspended_o && cmd_valid_i &&
         (cmd_code_i == CMD_SUSPEND || cmd_code_i == CMD_RESUME))
        |=> (ignore_o && !tmr_pause_o && !tmr_resume_o));

endmodule

// File: tb/pe_suspend_arbiter_test.sv
module pe_suspend_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic       tmr_done = 1'b0;
    logic busy, susp, ready, acc, ign, resp, tstart, tpause, tresume;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_suspend_arbiter uut (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .tmr_done_i(tmr_done), .busy_o(busy), .suspended_o(susp), .ready_o(ready),
        .accept_o(acc), .ignore_o(ign), .resp_bit_o(resp), .tmr_start_o(tstart),
        .tmr_pause_o(tpause), .tmr_resume_o(tresume)
    );

    typedef struct {
        logic [8:0] vec;   // acc ign resp start pause resume busy susp ready
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // bench model: 0 idle, 1 running, 2 suspended
    int m_st = 0;
    bit m_pausable = 0;

    task automatic step(input bit v, input int code, input bit done, input string tag);
        logic a, g, r, s, p, u;
        int nst;
        exp_t e;
        @(negedge clk);
        cmd_valid = v;
        cmd_code  = 4'(code);
        tmr_done  = done;
        {a, g, r, s, p, u} = '0;
        nst = m_st;
        if (m_st == 0) begin
            if (v && code >= 1 && code <= 7) begin
                a = 1; s = 1; nst = 1; m_pausable = (code <= 3);
            end else if (v && (code == 0 || code == 10 || code == 11)) begin
                a = 1; r = (code == 11);
            end else if (v) g = 1;
        end else if (m_st == 1) begin
            if (done) nst = 0;
            if (v && (code == 10 || code == 11)) begin
                a = 1; r = (code == 10);
            end else if (v && code == 8 && m_pausable && !done) begin
                a = 1; p = 1; nst = 2;
            end else if (v) g = 1;
        end else begin
            if (v && code == 9) begin
                a = 1; u = 1; nst = 1;
            end else if (v && (code == 0 || code == 10 || code == 11)) begin
                a = 1; r = (code == 11);
            end else if (v) g = 1;
        end
        m_st = nst;
        e.vec = {a, g, r, s, p, u, (m_st == 1), (m_st == 2), (m_st != 1)};
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            exp_t e;
            logic [8:0] act;
            e = q.pop_front();
            act = {acc, ign, resp, tstart, tpause, tresume, busy, susp, ready};
            n_cmp++;
            if (act !== e.vec) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.vec);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, "R1 reset state");
        step(1, 11, 0, "R4 flag poll idle");
        step(1, 10, 0, "R4 status poll idle");
        step(1, 9, 0, "R8 resume idle");
        step(1, 8, 0, "R8 suspend idle");
        step(1, 0, 0, "R2 array read idle");
        step(1, 1, 0, "R2 program start");
        step(0, 0, 0, "R2 start is one pulse");
        step(1, 0, 0, "R3 array read busy");
        step(1, 3, 0, "R3 sector erase busy");
        step(1, 10, 0, "R4 status poll busy");
        step(1, 11, 0, "R4 flag poll busy");
        step(1, 9, 0, "R8 resume running");
        step(1, 8, 0, "R5 suspend program");
        step(0, 0, 0, "R5 pause is one pulse");
        step(1, 10, 0, "R4 status poll suspended");
        step(1, 11, 0, "R4 flag poll suspended");
        step(1, 0, 0, "R9 array read suspended");
        step(1, 4, 0, "R9 bulk erase suspended");
        step(0, 0, 1, "R9 done ignored suspended");
        step(1, 8, 0, "R8 suspend suspended");
        step(1, 9, 0, "R7 resume");
        step(0, 0, 0, "R7 resume is one pulse");
        step(0, 0, 1, "R10 done ends cycle");
        step(1, 13, 0, "R11 unknown code idle");
        step(1, 15, 0, "R11 unknown code 15 idle");
        for (int k = 4; k < 8; k++) begin
            step(1, k, 0, "R2 non-pausable start");
            step(1, 8, 0, "R6 suspend refused");
            step(1, 12, 0, "R11 unknown code busy");
            step(0, 0, 1, "R10 done");
        end
        step(1, 2, 0, "R2 subsector erase start");
        step(1, 8, 1, "R10 suspend with done");
        step(1, 3, 0, "R2 sector erase start");
        step(1, 8, 0, "R5 suspend sector erase");
        step(1, 1, 0, "R9 program suspended");
        step(1, 9, 0, "R7 resume erase");
        step(1, 0, 1, "R10 read with done");
        step(0, 0, 0, "R1 back to idle");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule